// File: doc/BRIEF.md
# Dual-Slot Same-Word Hazard Resolver

This block sits in the issue stage of a processor whose instruction word has two slots. The upper slot does vector arithmetic. The lower slot handles loads, stores, integer operations and branches. Both slots share one vector register file and one clip-flag register. The decoders for each slot produce register-usage descriptors. From these the resolver decides how the two halves of a word interact. It can cancel the lower operation, or make the lower operation read the values from before the word executed. It can also turn the whole lower word into an immediate data value.

Every indication is combinational from the current word and its descriptors. The commit enables for the upper and lower results are registered, and they appear on the cycle after the word is issued. The register file and the functional units are outside this block. They are represented only by the descriptor inputs and the commit-enable outputs.

Top module: `slot_hazard_resolver`

## Requirements
- R1: When `issue` is high and bit 31 of `upper_word` is 1, the word is in immediate mode. In this mode `imm_write` is 1 and `imm_value` equals `lower_word`. `lower_op` is 0, and all lower descriptors are ignored: `lower_discard`, `lo_src0_old`, `lo_src1_old`, `lo_clip_old` and `branch_pending` are 0.
- R2: `upper_op` always equals `upper_word[5:0]`. Outside immediate mode, `lower_op` equals `lower_word[31:25]`.
- R3: Outside immediate mode, if `up_vf_dst` is nonzero and equals `lo_vf_dst`, then `lower_discard` is 1.
- R4: Outside immediate mode and without a discard, `lo_src0_old` is 1 exactly when `lo_vf_src0` equals a nonzero `up_vf_dst`. `lo_src1_old` follows the same rule for `lo_vf_src1`.
- R5: Outside immediate mode, if bit `CLIP_IDX` is set in both `up_ireg_rd` and `lo_ireg_wr`, then `lower_discard` is 1.
- R6: Outside immediate mode and without a discard, `lo_clip_old` is 1 exactly when bit `CLIP_IDX` is set in both `up_ireg_rd` and `lo_ireg_rd`.
- R7: `branch_pending` is 1 exactly when `issue` is high, the word is not in immediate mode, `lo_branch` is 1 and the lower operation is not discarded.
- R8: Vector register index 0 never causes a discard or an operand-select, whatever the other indices are.
- R9: One cycle after a word is presented, `commit_upper` equals the `issue` value that word had. `commit_lower` equals `issue` AND not immediate AND not discarded. Both commit enables are 0 after reset.
- R10: While `issue` is low, `imm_write`, `lower_discard`, the three old-value selects and `branch_pending` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | A word is presented this cycle |
| upper_word | input | 32 | Upper slot encoding; bit 31 selects immediate mode |
| lower_word | input | 32 | Lower slot encoding or immediate data |
| up_vf_dst | input | VW | Upper vector destination index (0 = none) |
| up_ireg_rd | input | IN | Upper integer/flag read mask |
| lo_vf_dst | input | VW | Lower vector destination index |
| lo_vf_src0 | input | VW | Lower first vector source index |
| lo_vf_src1 | input | VW | Lower second vector source index |
| lo_ireg_rd | input | IN | Lower integer/flag read mask |
| lo_ireg_wr | input | IN | Lower integer/flag write mask |
| lo_branch | input | 1 | Lower operation is a branch |
| upper_op | output | 6 | Upper opcode field |
| lower_op | output | 7 | Lower opcode field (0 in immediate mode) |
| imm_write | output | 1 | Write `imm_value` to the immediate register |
| imm_value | output | 32 | Immediate data |
| lower_discard | output | 1 | Cancel the lower operation |
| lo_src0_old | output | 1 | Lower source 0 reads the pre-word value |
| lo_src1_old | output | 1 | Lower source 1 reads the pre-word value |
| lo_clip_old | output | 1 | Lower reads the pre-word clip flag |
| branch_pending | output | 1 | Lower branch goes to the sequencer |
| commit_upper | output | 1 | Registered upper commit enable |
| commit_lower | output | 1 | Registered lower commit enable |

## Verification
The bench builds the block with `VW=2`, `IN=4` and `CLIP_IDX=2`, which gives four vector registers and a four-bit flag mask. At these sizes every combination of the upper destination and the three lower vector indices can be swept, including every case that involves index 0. Every combination of the three flag masks can be swept as well, so all orderings of clip reads and writes are reached. Immediate-mode words are run with conflicting descriptors to show that those descriptors are ignored. Words with `issue` low are also run, and the registered commit pair is checked one cycle after each word.

// File: rtl/slot_hazard_resolver.sv
module slot_hazard_resolver #(
  parameter int VW       = 6,
  parameter int IN       = 16,
  parameter int CLIP_IDX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [31:0]   upper_word,
  input  logic [31:0]   lower_word,
  input  logic [VW-1:0] up_vf_dst,
  input  logic [IN-1:0] up_ireg_rd,
  input  logic [VW-1:0] lo_vf_dst,
  input  logic [VW-1:0] lo_vf_src0,
  input  logic [VW-1:0] lo_vf_src1,
  input  logic [IN-1:0] lo_ireg_rd,
  input  logic [IN-1:0] lo_ireg_wr,
  input  logic          lo_branch,
  output logic [5:0]    upper_op,
  output logic [6:0]    lower_op,
  output logic          imm_write,
  output logic [31:0]   imm_value,
  output logic          lower_discard,
  output logic          lo_src0_old,
  output logic          lo_src1_old,
  output logic          lo_clip_old,
  output logic          branch_pending,
  output logic          commit_upper,
  output logic          commit_lower
);
  logic imm, lo_live, dst_nz, vf_clash, up_clip, clip_clash, keep;

  assign imm        = upper_word[31];
  assign lo_live    = issue & ~imm;
  assign dst_nz     = |up_vf_dst;
  assign vf_clash   = dst_nz & (lo_vf_dst == up_vf_dst);
  assign up_clip    = up_ireg_rd[CLIP_IDX];
  assign clip_clash = up_clip & lo_ireg_wr[CLIP_IDX];

  assign lower_discard = lo_live & (vf_clash | clip_clash);
  assign keep          = lo_live & ~(vf_clash | clip_clash);

  assign lo_src0_old    = keep & dst_nz & (lo_vf_src0 == up_vf_dst);
  assign lo_src1_old    = keep & dst_nz & (lo_vf_src1 == up_vf_dst);
  assign lo_clip_old    = keep & up_clip & lo_ireg_rd[CLIP_IDX];
  assign branch_pending = keep & lo_branch;

  assign upper_op  = upper_word[5:0];
  assign lower_op  = imm ? 7'd0 : lower_word[31:25];
  assign imm_write = issue & imm;
  assign imm_value = lower_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_upper <= 1'b0;
      commit_lower <= 1'b0;
    end else begin
      commit_upper <= issue;
      commit_lower <= keep;
    end
  end
endmodule

// File: rtl/slot_hazard_resolver_chk.sv
module slot_hazard_resolver_chk #(
  parameter int VW       = 6,
  parameter int IN       = 16,
  parameter int CLIP_IDX = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue,
  input logic [31:0]   upper_word,
  input logic [VW-1:0] up_vf_dst,
  input logic [IN-1:0] up_ireg_rd,
  input logic [VW-1:0] lo_vf_dst,
  input logic [IN-1:0] lo_ireg_wr,
  input logic          lower_discard,
  input logic          lo_src0_old,
  input logic          lo_src1_old,
  input logic          lo_clip_old,
  input logic          branch_pending,
  input logic          imm_write,
  input logic          commit_upper,
  input logic          commit_lower
);
  // R1
  imm_ignores_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && upper_word[31]) |-> (imm_write && !lower_discard && !branch_pending
      && !lo_src0_old && !lo_src1_old && !lo_clip_old));

  // R3
  same_dst_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !upper_word[31] && up_vf_dst != '0 && up_vf_dst == lo_vf_dst) |-> lower_discard);

  // R5
  clip_write_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !upper_word[31] && up_ireg_rd[CLIP_IDX] && lo_ireg_wr[CLIP_IDX]) |-> lower_discard);

  // R8
  zero_dst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_vf_dst == '0) |-> (!lo_src0_old && !lo_src1_old));

  // R9
  discard_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lower_discard |=> !commit_lower);

  // R9
  issue_commits_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> commit_upper);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> (!imm_write && !lower_discard && !branch_pending && !lo_clip_old));
endmodule

bind slot_hazard_resolver slot_hazard_resolver_chk #(.VW(VW), .IN(IN), .CLIP_IDX(CLIP_IDX)) chk_i (.*);

// File: tb/slot_hazard_resolver_tb_top.sv
`timescale 1ns/1ps
module slot_hazard_resolver_tb_top;
  localparam int VW = 2, IN = 4, CLIP = 2;

  logic clk = 0, rst_n = 0, issue = 0, lo_branch = 0;
  logic [31:0] upper_word = 0, lower_word = 0;
  logic [VW-1:0] up_vf_dst = 0, lo_vf_dst = 0, lo_vf_src0 = 0, lo_vf_src1 = 0;
  logic [IN-1:0] up_ireg_rd = 0, lo_ireg_rd = 0, lo_ireg_wr = 0;
  logic [5:0] upper_op; logic [6:0] lower_op; logic [31:0] imm_value;
  logic imm_write, lower_discard, lo_src0_old, lo_src1_old, lo_clip_old;
  logic branch_pending, commit_upper, commit_lower;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slot_hazard_resolver #(.VW(VW), .IN(IN), .CLIP_IDX(CLIP)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic iss, input logic [31:0] uw, input logic [31:0] lw,
                     input int ud, input int uir, input int ld, input int s0, input int s1,
                     input int lir, input int liw, input logic br);
    logic im, live, dis, keep;
    @(negedge clk);
    issue = iss; upper_word = uw; lower_word = lw; up_vf_dst = VW'(ud);
    up_ireg_rd = IN'(uir); lo_vf_dst = VW'(ld); lo_vf_src0 = VW'(s0); lo_vf_src1 = VW'(s1);
    lo_ireg_rd = IN'(lir); lo_ireg_wr = IN'(liw); lo_branch = br;
    #1;
    im   = uw[31];
    live = iss && !im;
    dis  = live && ((ud != 0 && ud == ld) || (uir[CLIP] && liw[CLIP]));
    keep = live && !dis;
    chk("R2 upper_op", 32'(upper_op), 32'(uw[5:0]));
    chk("R2/R1 lower_op", 32'(lower_op), im ? 32'd0 : 32'(lw[31:25]));
    chk("R1/R10 imm_write", 32'(imm_write), 32'(iss && im));
    if (iss && im) chk("R1 imm_value", imm_value, lw);
    chk("R3/R5/R8 lower_discard", 32'(lower_discard), 32'(dis));
    chk("R4/R8 lo_src0_old", 32'(lo_src0_old), 32'(keep && ud != 0 && s0 == ud));
    chk("R4/R8 lo_src1_old", 32'(lo_src1_old), 32'(keep && ud != 0 && s1 == ud));
    chk("R6 lo_clip_old", 32'(lo_clip_old), 32'(keep && uir[CLIP] && lir[CLIP]));
    chk("R7 branch_pending", 32'(branch_pending), 32'(keep && br));
    @(posedge clk); #1;
    chk("R9 commit_upper", 32'(commit_upper), 32'(iss));
    chk("R9 commit_lower", 32'(commit_lower), 32'(keep));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R9 reset commit_upper", 32'(commit_upper), 0);
    chk("R9 reset commit_lower", 32'(commit_lower), 0);
    rst_n = 1;
    // R3 R4 R8: every vector index combination
    for (int v = 0; v < 256; v++)
      run(1, {1'b0, 25'(v * 37), 6'(v)}, {7'(v), 25'(v * 11)}, v & 3, 0,
          (v >> 2) & 3, (v >> 4) & 3, (v >> 6) & 3, 0, 0, v[0]);
    // R5 R6: every flag mask combination
    for (int m = 0; m < 4096; m++)
      run(1, 32'(m), {7'(m >> 3), 25'd0}, 1, m & 15, 2, 3, 0,
          (m >> 4) & 15, (m >> 8) & 15, m[1]);
    // R1: immediate words with conflicting descriptors
    for (int k = 0; k < 64; k++)
      run(1, {1'b1, 25'(k), 6'(k)}, 32'hA5C3_0000 ^ 32'(k * 977), (k & 3) | 1, 15,
          (k & 3) | 1, (k & 3) | 1, (k & 3) | 1, 15, 15, 1);
    // R10: idle words
    for (int k = 0; k < 32; k++)
      run(0, {k[0], 31'(k * 3)}, 32'(k * 5), 1, 15, 1, 1, 1, 15, 15, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule